// File: doc/BRIEF.md
# Reconfigurable Region Control Register Bank

This block sits between a processor and up to eight swappable hardware regions. Software reaches it through an AXI4-Lite slave port. Through that port it can:

- start, pause and acknowledge the hardware tasks with one shared control word;
- enable each region and arm a per-region switch;
- read which regions are safe to reload;
- read how long the last reload took;
- keep eight user words per region, for example a task ID, a working mode or parameters.

Each region has its own small controller that makes a reload safe. An armed switch first waits for the region to finish the frame it is processing. The region then raises its ready flag. When the external configuration engine signals the start of a transfer, the region goes into reset and the controller counts clock cycles until the engine reports that the transfer is done. The region is then held in reset for a fixed number of cycles. After that it becomes active again by itself, and the switch request is cleared.

Each region has one interrupt line. A line is raised when the region's interrupt is enabled and its latched status bit is set. The status bit is latched either by an event pulse from the task or by the region becoming ready for reload.

Top module: `rrc_bank`

## Requirements
- R1: Every AXI4-Lite write and read completes with an OKAY response (code 0). A user word at byte offset 0x200 + 32*region + 4*index reads back the bytes last written to it, and only the byte lanes whose write strobe bit was set are updated.
- R2: An access to any address outside the map reads as zero, and a write to it changes no readable register. The map holds the control word at 0x000, the interrupt word at 0x004, the region word at 0x008, the ready word at 0x00C, the delay words at 0x100 + 4*region, and the user words.
- R3: In the control word at 0x000, bit 0 drives `proc_start_o` and bit 1 drives `proc_pause_o` as levels. Writing bit 2 as 1 gives exactly one clock cycle of `proc_handled_o`. Bit 2 always reads as 0.
- R4: In the interrupt word at 0x004, bits 7:0 are read/write interrupt enables, one per region. Bits 15:8 are the status bits. Writing 1 to a status bit clears it, and writing 0 to it leaves it unchanged.
- R5: A region's status bit is set by a pulse on `task_event_i` or when the region becomes ready for reload. `irq_o[r]` is high exactly when both the enable bit and the status bit of region r are set.
- R6: In the region word at 0x008, bits 7:0 are region enables and bits 15:8 are switch requests. A region drives `region_active_o` only while its enable bit is set and it is not being reloaded.
- R7: While `frame_busy_i` of a region with an armed switch stays high, its ready flag stays low and the region stays active. The flag rises only after `frame_busy_i` falls.
- R8: The ready word at 0x00C has one flag per region in bits 7:0. Writes to it are ignored. A flag clears when the configuration transfer starts.
- R9: A `cfg_start_i` pulse on a region that is not ready is ignored: the region does not enter reset and its delay word is unchanged.
- R10: The delay word of a region reads N when `cfg_done_i` is sampled N clock cycles after `cfg_start_i`. While the transfer runs, the count saturates at all ones.
- R11: `region_rst_o` is high from the transfer start until HOLD_CYC cycles after `cfg_done_i`. After that the region becomes active again without any software action, and its switch-request bit reads as 0.
- R12: After reset all registers read zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| frame_busy_i | input | N_REGIONS | Region is in the middle of a frame |
| task_event_i | input | N_REGIONS | Completion or error pulse from a task |
| cfg_start_i | input | N_REGIONS | Configuration transfer start strobe |
| cfg_done_i | input | N_REGIONS | Configuration transfer done strobe |
| region_active_o | output | N_REGIONS | Region may run its task |
| region_rst_o | output | N_REGIONS | Region held in reset |
| irq_o | output | N_REGIONS | Per-region interrupt line |
| proc_start_o | output | 1 | Start level to all tasks |
| proc_pause_o | output | 1 | Pause level to all tasks |
| proc_handled_o | output | 1 | One-cycle interrupt-handled pulse |

## Verification
The bench holds a region mid-frame with a switch armed for many cycles. A design that skipped the frame gate would raise the ready flag too early, and it would stop the region while the frame is still running.

The reload interval is timed to the exact cycle. This exposes an off-by-one delay count, a reset hold of the wrong length, and a region that never comes back active on its own. A separate long transfer checks that the counter saturates and does not wrap.

Stray start strobes on a running region are checked to have no effect. The interrupt word is driven with clears and zero-writes, which catches a status bit cleared by a zero-write and an interrupt line that ignores its enable bit.

// File: rtl/rrc_pkg.sv
`timescale 1ns/1ps
package rrc_pkg;

   typedef enum logic [2:0] {
      RG_RUN,
      RG_DRAIN,
      RG_READY,
      RG_LOAD,
      RG_HOLD
   } rg_state_e;

   typedef enum logic [2:0] {
      AK_NONE,
      AK_PROC,
      AK_IRQ,
      AK_RSTAT,
      AK_READY,
      AK_DELAY,
      AK_GPR
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e  kind;
      logic [2:0] reg_idx;
      logic [2:0] gpr_idx;
   } acc_t;

   // Address decode shared by the write and read paths
   function automatic acc_t decode_addr(input logic [31:0] a,
                                        input int unsigned n_reg,
                                        input int unsigned n_gpr);
      acc_t d;
      d.kind    = AK_NONE;
      d.reg_idx = a[7:5];
      d.gpr_idx = a[4:2];
      if (a[1:0] == 2'b00) begin
         if (a[31:2] == 30'h0)      d.kind = AK_PROC;
         else if (a[31:2] == 30'h1) d.kind = AK_IRQ;
         else if (a[31:2] == 30'h2) d.kind = AK_RSTAT;
         else if (a[31:2] == 30'h3) d.kind = AK_READY;
         else if (a[31:5] == 27'h8 && {29'b0, a[4:2]} < n_reg) begin
            d.kind    = AK_DELAY;
            d.reg_idx = a[4:2];
         end else if (a[31:8] == 24'h2 && {29'b0, a[7:5]} < n_reg &&
                      {29'b0, a[4:2]} < n_gpr) begin
            d.kind = AK_GPR;
         end
      end
      return d;
   endfunction

   function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  strb);
      logic [31:0] res;
      for (int b = 0; b < 4; b++)
         res[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
      return res;
   endfunction

endpackage

// File: rtl/rrc_axil_port.sv
`timescale 1ns/1ps
module rrc_axil_port #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [31:0]       s_wdata,
   input  logic [3:0]        s_wstrb,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   output logic [3:0]        wr_strb,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [31:0]       rd_data
);

   logic        bvalid_q;
   logic        rvalid_q;
   logic [31:0] rdata_q;
   logic        rd_take;

   // Address and data are accepted together once no response is pending
   assign wr_en     = s_awvalid & s_wvalid & ~bvalid_q;
   assign s_awready = wr_en;
   assign s_wready  = wr_en;
   assign wr_addr   = s_awaddr;
   assign wr_data   = s_wdata;
   assign wr_strb   = s_wstrb;

   assign rd_take   = s_arvalid & ~rvalid_q;
   assign s_arready = ~rvalid_q;
   assign rd_addr   = s_araddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (wr_en)         bvalid_q <= 1'b1;
         else if (s_bready) bvalid_q <= 1'b0;
         if (rd_take) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_data;
         end else if (s_rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   assign s_bvalid = bvalid_q;
   assign s_bresp  = 2'b00;
   assign s_rvalid = rvalid_q;
   assign s_rdata  = rdata_q;
   assign s_rresp  = 2'b00;

endmodule

// File: rtl/rrc_region_ctrl.sv
`timescale 1ns/1ps
module rrc_region_ctrl
   import rrc_pkg::*;
#(
   parameter int DELAY_W  = 32,
   parameter int HOLD_CYC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               sw_req_i,
   input  logic               frame_busy_i,
   input  logic               cfg_start_i,
   input  logic               cfg_done_i,
   output logic               active_o,
   output logic               region_rst_o,
   output logic               ready_o,
   output logic               ready_rise_o,
   output logic               sw_clr_o,
   output logic [DELAY_W-1:0] delay_o
);

   localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [DELAY_W-1:0] DELAY_MAX = '1;

   rg_state_e          state_q, state_d;
   logic [DELAY_W-1:0] delay_q;
   logic               hold_last;

   // Reset hold length: a single cycle needs no counter
   generate
      if (HOLD_CYC == 1) begin : g_hold_one
         assign hold_last = 1'b1;
      end else begin : g_hold_cnt
         logic [HOLD_W-1:0] hold_cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || state_q != RG_HOLD) hold_cnt_q <= '0;
            else                              hold_cnt_q <= hold_cnt_q + 1'b1;
         end
         assign hold_last = (hold_cnt_q == HOLD_W'(HOLD_CYC - 1));
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RG_RUN:   if (sw_req_i)      state_d = RG_DRAIN;
         RG_DRAIN: if (!frame_busy_i) state_d = RG_READY;
         RG_READY: if (cfg_start_i)   state_d = RG_LOAD;
         RG_LOAD:  if (cfg_done_i)    state_d = RG_HOLD;
         RG_HOLD:  if (hold_last)     state_d = RG_RUN;
         default:                     state_d = RG_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RG_RUN;
         delay_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == RG_READY && cfg_start_i)
            delay_q <= DELAY_W'(1);
         else if (state_q == RG_LOAD && !cfg_done_i && delay_q != DELAY_MAX)
            delay_q <= delay_q + 1'b1;
      end
   end

   assign active_o     = en_i && (state_q == RG_RUN || state_q == RG_DRAIN);
   assign region_rst_o = (state_q == RG_LOAD) || (state_q == RG_HOLD);
   assign ready_o      = (state_q == RG_READY);
   assign ready_rise_o = (state_q == RG_DRAIN) && !frame_busy_i;
   assign sw_clr_o     = (state_q == RG_HOLD) && hold_last;
   assign delay_o      = delay_q;

endmodule

// File: rtl/rrc_regs.sv
`timescale 1ns/1ps
module rrc_regs
   import rrc_pkg::*;
#(
   parameter int N_REGIONS = 8,
   parameter int N_GPR     = 8,
   parameter int ADDR_W    = 10,
   parameter int DELAY_W   = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [31:0]                          wr_data,
   input  logic [3:0]                           wr_strb,
   input  logic [ADDR_W-1:0]                    rd_addr,
   output logic [31:0]                          rd_data,
   input  logic [N_REGIONS-1:0]                 ready_i,
   input  logic [N_REGIONS-1:0][DELAY_W-1:0]    delay_i,
   input  logic [N_REGIONS-1:0]                 evt_set_i,
   input  logic [N_REGIONS-1:0]                 sw_clr_i,
   output logic [N_REGIONS-1:0]                 en_o,
   output logic [N_REGIONS-1:0]                 sw_o,
   output logic [N_REGIONS-1:0]                 irq_o,
   output logic                                 proc_start_o,
   output logic                                 proc_pause_o,
   output logic                                 proc_handled_o
);

   acc_t                 wd, rd;
   logic [1:0]           proc_q;
   logic                 handled_q;
   logic [N_REGIONS-1:0] irq_en_q, irq_st_q, en_q, sw_q;
   logic [N_REGIONS-1:0] w1c, sw_nxt;
   logic [31:0]          gpr_q [N_REGIONS][N_GPR];

   assign wd = decode_addr(32'(wr_addr), N_REGIONS, N_GPR);
   assign rd = decode_addr(32'(rd_addr), N_REGIONS, N_GPR);

   always_comb begin
      w1c    = '0;
      sw_nxt = sw_q;
      if (wr_en && wd.kind == AK_IRQ && wr_strb[1])
         w1c = wr_data[8 +: N_REGIONS];
      if (wr_en && wd.kind == AK_RSTAT && wr_strb[1])
         sw_nxt = wr_data[8 +: N_REGIONS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         proc_q    <= '0;
         handled_q <= 1'b0;
         irq_en_q  <= '0;
         irq_st_q  <= '0;
         en_q      <= '0;
         sw_q      <= '0;
         for (int r = 0; r < N_REGIONS; r++)
            for (int g = 0; g < N_GPR; g++)
               gpr_q[r][g] <= '0;
      end else begin
         handled_q <= 1'b0;
         // Set sources win over a clear in the same cycle
         irq_st_q  <= (irq_st_q & ~w1c) | evt_set_i;
         sw_q      <= sw_nxt & ~sw_clr_i;
         if (wr_en) begin
            unique case (wd.kind)
               AK_PROC: if (wr_strb[0]) begin
                  proc_q    <= wr_data[1:0];
                  handled_q <= wr_data[2];
               end
               AK_IRQ:   if (wr_strb[0]) irq_en_q <= wr_data[N_REGIONS-1:0];
               AK_RSTAT: if (wr_strb[0]) en_q     <= wr_data[N_REGIONS-1:0];
               AK_GPR:
                  gpr_q[wd.reg_idx][wd.gpr_idx] <=
                     merge_bytes(gpr_q[wd.reg_idx][wd.gpr_idx], wr_data, wr_strb);
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd.kind)
         AK_PROC:  rd_data = {30'b0, proc_q};
         AK_IRQ:   rd_data = {16'b0, 8'(irq_st_q), 8'(irq_en_q)};
         AK_RSTAT: rd_data = {16'b0, 8'(sw_q), 8'(en_q)};
         AK_READY: rd_data = {24'b0, 8'(ready_i)};
         AK_DELAY: rd_data = 32'(delay_i[rd.reg_idx]);
         AK_GPR:   rd_data = gpr_q[rd.reg_idx][rd.gpr_idx];
         default:  rd_data = '0;
      endcase
   end

   assign en_o           = en_q;
   assign sw_o           = sw_q;
   assign irq_o          = irq_en_q & irq_st_q;
   assign proc_start_o   = proc_q[0];
   assign proc_pause_o   = proc_q[1];
   assign proc_handled_o = handled_q;

endmodule

// File: rtl/rrc_bank.sv
`timescale 1ns/1ps
module rrc_bank #(
   parameter int N_REGIONS = 8,
   parameter int N_GPR     = 8,
   parameter int ADDR_W    = 10,
   parameter int DELAY_W   = 32,
   parameter int HOLD_CYC  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s_awvalid,
   output logic                 s_awready,
   input  logic [ADDR_W-1:0]    s_awaddr,
   input  logic                 s_wvalid,
   output logic                 s_wready,
   input  logic [31:0]          s_wdata,
   input  logic [3:0]           s_wstrb,
   output logic                 s_bvalid,
   input  logic                 s_bready,
   output logic [1:0]           s_bresp,
   input  logic                 s_arvalid,
   output logic                 s_arready,
   input  logic [ADDR_W-1:0]    s_araddr,
   output logic                 s_rvalid,
   input  logic                 s_rready,
   output logic [31:0]          s_rdata,
   output logic [1:0]           s_rresp,
   input  logic [N_REGIONS-1:0] frame_busy_i,
   input  logic [N_REGIONS-1:0] task_event_i,
   input  logic [N_REGIONS-1:0] cfg_start_i,
   input  logic [N_REGIONS-1:0] cfg_done_i,
   output logic [N_REGIONS-1:0] region_active_o,
   output logic [N_REGIONS-1:0] region_rst_o,
   output logic [N_REGIONS-1:0] irq_o,
   output logic                 proc_start_o,
   output logic                 proc_pause_o,
   output logic                 proc_handled_o
);

   generate
      if (N_REGIONS < 1 || N_REGIONS > 8) begin : g_bad_regions
         $error("N_REGIONS must lie in 1..8");
      end
      if (N_GPR < 1 || N_GPR > 8) begin : g_bad_gpr
         $error("N_GPR must lie in 1..8");
      end
      if (ADDR_W < 10 || ADDR_W > 31) begin : g_bad_addr
         $error("ADDR_W must lie in 10..31");
      end
      if (DELAY_W < 1 || DELAY_W > 32) begin : g_bad_delay
         $error("DELAY_W must lie in 1..32");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
   endgenerate

   logic                              wr_en;
   logic [ADDR_W-1:0]                 wr_addr, rd_addr;
   logic [31:0]                       wr_data, rd_data;
   logic [3:0]                        wr_strb;
   logic [N_REGIONS-1:0]              en_w, sw_w, ready_w, ready_rise_w, sw_clr_w;
   logic [N_REGIONS-1:0][DELAY_W-1:0] delay_w;

   rrc_axil_port #(.ADDR_W(ADDR_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
      .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   rrc_regs #(
      .N_REGIONS(N_REGIONS), .N_GPR(N_GPR), .ADDR_W(ADDR_W), .DELAY_W(DELAY_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ready_i(ready_w), .delay_i(delay_w),
      .evt_set_i(task_event_i | ready_rise_w), .sw_clr_i(sw_clr_w),
      .en_o(en_w), .sw_o(sw_w), .irq_o(irq_o),
      .proc_start_o(proc_start_o), .proc_pause_o(proc_pause_o),
      .proc_handled_o(proc_handled_o)
   );

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
      rrc_region_ctrl #(.DELAY_W(DELAY_W), .HOLD_CYC(HOLD_CYC)) u_ctrl (
         .clk(clk), .rst_n(rst_n),
         .en_i(en_w[r]), .sw_req_i(sw_w[r]), .frame_busy_i(frame_busy_i[r]),
         .cfg_start_i(cfg_start_i[r]), .cfg_done_i(cfg_done_i[r]),
         .active_o(region_active_o[r]), .region_rst_o(region_rst_o[r]),
         .ready_o(ready_w[r]), .ready_rise_o(ready_rise_w[r]),
         .sw_clr_o(sw_clr_w[r]), .delay_o(delay_w[r])
      );
   end

endmodule

// File: rtl/rrc_bank_chk.sv
`timescale 1ns/1ps
module rrc_bank_chk #(
   parameter int N_REGIONS = 8,
   parameter int DELAY_W   = 32
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              s_awvalid,
   input logic                              s_awready,
   input logic                              s_bvalid,
   input logic                              s_rvalid,
   input logic                              s_rready,
   input logic [31:0]                       s_rdata,
   input logic                              proc_handled_o,
   input logic [N_REGIONS-1:0]              frame_busy_i,
   input logic [N_REGIONS-1:0]              ready_w,
   input logic [N_REGIONS-1:0]              region_rst_o,
   input logic [N_REGIONS-1:0]              region_active_o,
   input logic [N_REGIONS-1:0][DELAY_W-1:0] delay_w
);

   assert_wr_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready) |=> s_bvalid);

   assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

   assert_handled_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      proc_handled_o |=> !proc_handled_o);

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_chk
      assert_rst_blocks_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
         region_rst_o[r] |-> !region_active_o[r]);

      assert_ready_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ready_w[r]) |-> !$past(frame_busy_i[r]));

      assert_leave_ready_into_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ready_w[r]) |-> region_rst_o[r]);

      assert_delay_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ((delay_w[r] == {DELAY_W{1'b1}}) && !ready_w[r]) |=> (delay_w[r] == {DELAY_W{1'b1}}));
   end

endmodule

bind rrc_bank rrc_bank_chk #(.N_REGIONS(N_REGIONS), .DELAY_W(DELAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .s_awvalid(s_awvalid), .s_awready(s_awready), .s_bvalid(s_bvalid),
   .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
   .proc_handled_o(proc_handled_o), .frame_busy_i(frame_busy_i),
   .ready_w(ready_w), .region_rst_o(region_rst_o),
   .region_active_o(region_active_o), .delay_w(delay_w)
);

// File: tb/rrc_bank_bench.sv
`timescale 1ns/1ps
module rrc_bank_bench;

   localparam int NR = 8;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int HOLD = 4;
   localparam int NV = 24;

   // {req(4), write(1), addr(10), data(32), strb(4), expected(32)}
   localparam logic [82:0] VECS [0:NV-1] = '{
      {4'd1,  1'b1, 10'h200, 32'hDEADBEEF, 4'hF, 32'h0},          // R1
      {4'd1,  1'b0, 10'h200, 32'h0,        4'h0, 32'hDEADBEEF},
      {4'd1,  1'b1, 10'h2FC, 32'h12345678, 4'hF, 32'h0},
      {4'd1,  1'b0, 10'h2FC, 32'h0,        4'h0, 32'h12345678},
      {4'd1,  1'b1, 10'h204, 32'hFFFFFFFF, 4'h1, 32'h0},
      {4'd1,  1'b0, 10'h204, 32'h0,        4'h0, 32'h000000FF},
      {4'd1,  1'b1, 10'h204, 32'hAABBCCDD, 4'h6, 32'h0},
      {4'd1,  1'b0, 10'h204, 32'h0,        4'h0, 32'h00BBCCFF},
      {4'd2,  1'b1, 10'h080, 32'hFFFFFFFF, 4'hF, 32'h0},          // R2
      {4'd2,  1'b0, 10'h080, 32'h0,        4'h0, 32'h0},
      {4'd2,  1'b1, 10'h300, 32'hFFFFFFFF, 4'hF, 32'h0},
      {4'd2,  1'b0, 10'h300, 32'h0,        4'h0, 32'h0},
      {4'd8,  1'b1, 10'h00C, 32'h000000FF, 4'hF, 32'h0},          // R8
      {4'd8,  1'b0, 10'h00C, 32'h0,        4'h0, 32'h0},
      {4'd10, 1'b0, 10'h100, 32'h0,        4'h0, 32'h0},          // R10
      {4'd6,  1'b1, 10'h008, 32'h000000FF, 4'hF, 32'h0},          // R6
      {4'd6,  1'b0, 10'h008, 32'h0,        4'h0, 32'h000000FF},
      {4'd4,  1'b1, 10'h004, 32'h00000004, 4'hF, 32'h0},          // R4
      {4'd4,  1'b0, 10'h004, 32'h0,        4'h0, 32'h00000004},
      {4'd3,  1'b1, 10'h000, 32'h00000003, 4'hF, 32'h0},          // R3
      {4'd3,  1'b0, 10'h000, 32'h0,        4'h0, 32'h00000003},
      {4'd3,  1'b1, 10'h000, 32'h00000000, 4'hF, 32'h0},
      {4'd3,  1'b0, 10'h000, 32'h0,        4'h0, 32'h00000000},
      {4'd2,  1'b0, 10'h3FC, 32'h0,        4'h0, 32'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          awvalid = 0, wvalid = 0, arvalid = 0;
   logic          awready, wready, bvalid, arready, rvalid;
   logic [AW-1:0] awaddr = '0, araddr = '0;
   logic [31:0]   wdata = '0, rdata;
   logic [3:0]    wstrb = '0;
   logic [1:0]    bresp, rresp;
   logic [NR-1:0] busy = '0, evt = '0, cstart = '0, cdone = '0;
   logic [NR-1:0] active, rrst, irq;
   logic          pstart, ppause, phandled;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rrc_bank #(.N_REGIONS(NR), .ADDR_W(AW), .DELAY_W(DW), .HOLD_CYC(HOLD)) u_rrc_bank (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
      .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
      .s_bvalid(bvalid), .s_bready(1'b1), .s_bresp(bresp),
      .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
      .s_rvalid(rvalid), .s_rready(1'b1), .s_rdata(rdata), .s_rresp(rresp),
      .frame_busy_i(busy), .task_event_i(evt), .cfg_start_i(cstart), .cfg_done_i(cdone),
      .region_active_o(active), .region_rst_o(rrst), .irq_o(irq),
      .proc_start_o(pstart), .proc_pause_o(ppause), .proc_handled_o(phandled)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      awvalid = 1'b1; wvalid = 1'b1; awaddr = a; wdata = d; wstrb = s;
      while (!awready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0;
      check("R1 bresp", 32'(bresp), 32'h0);
   endtask

   task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      arvalid = 1'b1; araddr = a;
      while (!arready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      arvalid = 1'b0;
      d = rdata;
      check("R1 rresp", 32'(rresp), 32'h0);
   endtask

   task automatic read_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      axi_read(a, v);
      check(req, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      int cnt;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      check("R12 outputs", {active, rrst, irq, 5'b0, pstart, ppause, phandled}, 32'h0);
      read_check("R12 irq word", 10'h004, 32'h0);
      read_check("R12 region word", 10'h008, 32'h0);
      read_check("R12 gpr", 10'h2E0, 32'h0);

      // Register-level vector walk
      for (int i = 0; i < NV; i++) begin
         logic [82:0] e;
         e = VECS[i];
         if (e[78]) begin
            axi_write(e[77:68], e[67:36], e[35:32]);
         end else begin
            axi_read(e[77:68], v);
            n_vec++;
            if (v !== e[31:0]) begin
               n_bad++;
               $display("FAIL vector %0d (R%0d): actual %h expected %h", i, e[82:79], v, e[31:0]);
            end
         end
      end

      // R3 control levels and handled pulse
      axi_write(10'h000, 32'h3, 4'hF);
      check("R3 start/pause levels", {30'b0, pstart, ppause}, 32'h3);
      axi_write(10'h000, 32'h4, 4'hF);
      check("R3 handled pulse high", {31'b0, phandled}, 32'h1);
      check("R3 levels cleared", {30'b0, pstart, ppause}, 32'h0);
      @(negedge clk);
      check("R3 handled pulse one cycle", {31'b0, phandled}, 32'h0);
      read_check("R3 bit2 reads zero", 10'h000, 32'h0);

      // R6 enable gating
      check("R6 all active", 32'(active), 32'hFF);
      axi_write(10'h008, 32'h00F7, 4'hF);
      check("R6 region 3 disabled", 32'(active), 32'hF7);

      // R7 frame gate on region 2
      busy[2] = 1'b1;
      axi_write(10'h008, 32'h04F7, 4'hF);
      repeat (20) @(negedge clk);
      read_check("R7 not ready mid-frame", 10'h00C, 32'h0);
      check("R7 active during drain", 32'(active[2]), 32'h1);
      check("R5 no irq before ready", 32'(irq), 32'h0);
      busy[2] = 1'b0;
      repeat (3) @(negedge clk);
      read_check("R8 ready flag", 10'h00C, 32'h04);
      check("R5 ready irq", 32'(irq), 32'h04);
      read_check("R5 status latched", 10'h004, 32'h0404);
      check("R6 inactive when ready", 32'(active[2]), 32'h0);

      // R9 stray start on running region 4
      @(negedge clk); cstart[4] = 1'b1;
      @(negedge clk); cstart[4] = 1'b0;
      check("R9 no reset on stray start", 32'(rrst[4]), 32'h0);
      repeat (5) @(negedge clk);
      cdone[4] = 1'b1;
      @(negedge clk); cdone[4] = 1'b0;
      read_check("R9 delay untouched", 10'h110, 32'h0);
      check("R9 region 4 still active", 32'(active[4]), 32'h1);

      // R10 / R11 timed reload of region 2: done 37 cycles after start
      @(negedge clk); cstart[2] = 1'b1;
      @(negedge clk); cstart[2] = 1'b0;
      check("R11 reset during load", 32'(rrst[2]), 32'h1);
      repeat (36) @(negedge clk);
      cdone[2] = 1'b1;
      @(negedge clk); cdone[2] = 1'b0;
      cnt = 0;
      while (rrst[2] && cnt < 50) begin
         cnt++;
         @(negedge clk);
      end
      check("R11 hold length", 32'(cnt), 32'(HOLD));
      check("R11 auto active", 32'(active[2]), 32'h1);
      read_check("R10 delay count", 10'h108, 32'd37);
      read_check("R11 switch bit cleared", 10'h008, 32'h00F7);

      // R4 / R5 interrupt word behaviour
      axi_write(10'h004, 32'h0404, 4'hF);
      read_check("R4 w1c clears", 10'h004, 32'h0004);
      check("R5 line drops", 32'(irq), 32'h0);
      @(negedge clk); evt[5] = 1'b1;
      @(negedge clk); evt[5] = 1'b0;
      read_check("R5 event latched", 10'h004, 32'h2004);
      check("R5 masked line", 32'(irq), 32'h0);
      axi_write(10'h004, 32'h0024, 4'hF);
      check("R5 enabled line", 32'(irq), 32'h20);
      read_check("R4 zero write keeps status", 10'h004, 32'h2024);
      axi_write(10'h004, 32'h2024, 4'hF);
      read_check("R4 w1c region 5", 10'h004, 32'h0024);
      check("R5 line cleared", 32'(irq), 32'h0);

      // R10 saturation and R8 clear on start, region 6
      axi_write(10'h008, 32'h40F7, 4'hF);
      repeat (5) @(negedge clk);
      read_check("R8 region 6 ready", 10'h00C, 32'h40);
      @(negedge clk); cstart[6] = 1'b1;
      @(negedge clk); cstart[6] = 1'b0;
      read_check("R8 ready cleared on start", 10'h00C, 32'h0);
      repeat (300) @(negedge clk);
      read_check("R10 saturated delay", 10'h118, 32'hFF);
      cdone[6] = 1'b1;
      @(negedge clk); cdone[6] = 1'b0;
      repeat (10) @(negedge clk);
      check("R11 region 6 back active", 32'(active[6]), 32'h1);
      read_check("R10 delay held after done", 10'h118, 32'hFF);

      summary();
   end

endmodule